// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a regular tick for an operating system or scheduler. A prescaler divides the system clock by a fixed ratio, 16 by default. Each divided pulse advances a 20-bit live counter. When the counter reaches a programmed limit it returns to zero on the next pulse. At that point a 12-bit period counter steps and a status flag is raised. The flag drives an interrupt output whenever the interrupt-enable bit is set. With a divide ratio of 16, a tick rate R needs the limit `clk / (16·R) − 1`.

Software works through a plain register bus. A control word holds the limit and two enable bits. A status word holds the flag. Two read windows return the same packed word: period count above the live counter. Reading the acknowledge window clears the period count and the flag. Reading the snapshot window has no side effect.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset the control word reads 0x000FFFFF, and status and both windows read 0. `irq` is low and `rvalid` is low.
- R2: While running, the live counter advances by one every 16 enabled clock cycles.
- R3: When a prescaled pulse arrives with the live counter at or above the limit, the counter returns to 0, the period count increases by one and the flag is set. The tick period is therefore 16·(limit+1) cycles.
- R4: The control word is at byte offset 0x0. The limit is in bits 19:0, run enable is bit 24 and interrupt enable is bit 25. It reads back as written, with all other bits 0.
- R5: A read at offset 0x8 (acknowledge window) returns {period count[31:20], live counter[19:0]}. It then clears the period count and the flag.
- R6: A read at offset 0xC (snapshot window) returns the same packed word and changes no state.
- R7: `irq` is high exactly when the flag and interrupt enable are both set. The status word at offset 0x4 shows the flag in bit 0.
- R8: While run enable is 0, the live counter and the prescaler phase hold their values. Setting run enable again resumes counting from the held phase.
- R9: If a wrap and an acknowledge read fall in the same cycle, the period count becomes 1 and the flag stays set.
- R10: The period count wraps from 4095 to 0 (default). A parameter selects saturation at 4095 instead.
- R11: Writes to offsets 0x4, 0x8 and 0xC are ignored. A write to offset 0x8 does not clear anything.
- R12: `rvalid` is high in the cycle after `rd_en` is sampled, and only then. `rdata` holds the state as it was at the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 4 | Byte offset; bits 3:2 select the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | Read data valid |
| irq | output | 1 | Interrupt request, level |

## Verification
A write to the control word takes effect at its sampling edge, so counting starts on the next edge. After n further enabled edges the live counter holds floor(n/16). The flag and `irq` change in the same cycle as the wrapping edge. A read returns the state from before its own edge, and that state appears one cycle later with `rvalid`. The bench drives every strobe on a falling edge and counts enabled edges between the enabling write and each read's sampling edge. From that count it predicts the counter, the period count and the flag. Each read is timed so that the edge under test lands on an exact multiple of 16; the collision case is placed the same way.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 32;
  localparam int RUN_BIT = 24;
  localparam int IE_BIT = 25;

  typedef enum logic [1:0] {
    WIN_CTRL   = 2'd0,
    WIN_STATUS = 2'd1,
    WIN_ACK    = 2'd2,
    WIN_SNAP   = 2'd3
  } win_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else if (run) phase <= tick ? '0 : phase + 1'b1;
  end

  // R8: phase frozen while stopped
  a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(phase));
  // R2: after a pulse, phase restarts
  a_r2_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase == '0);
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 20,
  parameter int PCNT_W = 12,
  parameter bit PCNT_SAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  limit,
  input  logic              clr,
  output logic [CNT_W-1:0]  cnt,
  output logic [PCNT_W-1:0] pcnt,
  output logic              flag
);
  logic              wrap;
  logic [PCNT_W-1:0] pcnt_next;

  assign wrap = tick && (cnt >= limit);

  generate
    if (PCNT_SAT) begin : g_sat
      assign pcnt_next = (&pcnt) ? pcnt : pcnt + 1'b1;
    end else begin : g_wrap
      assign pcnt_next = pcnt + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pcnt <= '0;
      flag <= 1'b0;
    end else begin
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        pcnt <= clr ? PCNT_W'(1) : pcnt_next;
        flag <= 1'b1;
      end else if (clr) begin
        pcnt <= '0;
        flag <= 1'b0;
      end
    end
  end

  // R3: wrap returns the counter to zero and raises the flag
  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt >= limit) |=> (cnt == '0) && flag);
  // R2: counter moves only on a prescaled pulse
  a_r2_cnt_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R9: collision keeps one period and the flag
  a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt >= limit && clr) |=> (pcnt == PCNT_W'(1)) && flag);
  // R5: acknowledge without wrap clears
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(tick && cnt >= limit)) |=> (pcnt == '0) && !flag);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int PCNT_W = 12,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PCNT_W-1:0] pcnt,
  input  logic              flag,
  output logic [CNT_W-1:0]  limit,
  output logic              run,
  output logic              ie,
  output logic              clr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  win_e              win;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rd_word;
  logic              unused_bits;

  assign win = win_e'(addr[3:2]);
  assign clr = rd_en && (win == WIN_ACK);
  assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:IE_BIT+1], wdata[RUN_BIT-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit <= '1;
      run   <= 1'b0;
      ie    <= 1'b0;
    end else if (wr_en && win == WIN_CTRL) begin
      limit <= wdata[CNT_W-1:0];
      run   <= wdata[RUN_BIT];
      ie    <= wdata[IE_BIT];
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CNT_W-1:0] = limit;
    ctrl_word[RUN_BIT] = run;
    ctrl_word[IE_BIT] = ie;
  end

  always_comb begin
    case (win)
      WIN_CTRL:   rd_word = ctrl_word;
      WIN_STATUS: rd_word = {{(DATA_W-1){1'b0}}, flag};
      default:    rd_word = {pcnt, cnt};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  // R12: read strobe answered next cycle
  a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  // R11: writes elsewhere leave control untouched
  a_r11_ro_windows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && win != WIN_CTRL) |=> $stable(limit) && $stable(run) && $stable(ie));
endmodule

// File: rtl/interval_tick_timer.sv
module interval_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DIV = 16,
  parameter int CNT_W = 20,
  parameter int PCNT_W = 12,
  parameter int ADDR_W = 4,
  parameter bit PCNT_SAT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              irq
);
  localparam int PACK_W = CNT_W + PCNT_W;

  logic              tick, run, ie, clr, flag;
  logic [CNT_W-1:0]  limit, cnt;
  logic [PCNT_W-1:0] pcnt;

  tick_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  tick_counter #(.CNT_W(CNT_W), .PCNT_W(PCNT_W), .PCNT_SAT(PCNT_SAT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .limit(limit), .clr(clr),
    .cnt(cnt), .pcnt(pcnt), .flag(flag)
  );

  tick_regs #(.CNT_W(CNT_W), .PCNT_W(PCNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .pcnt(pcnt), .flag(flag), .limit(limit),
    .run(run), .ie(ie), .clr(clr), .rdata(rdata), .rvalid(rvalid)
  );

  assign irq = flag && ie;

  initial begin
    a_r5_pack_width: assert (PACK_W == DATA_W);
  end

  // R7: a request is withdrawn on the cycle after an acknowledge without wrap
  a_r7_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !tick) |=> !irq);
endmodule

// File: tb/interval_tick_timer_bench.sv
`timescale 1ns/1ps
module interval_tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        irq;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] d;

  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_ACK = 4'h8, A_SNAP = 4'hC;
  localparam int NV = 7;
  localparam int V_LIM [NV]  = '{3, 3, 3, 3, 0, 5, 9};
  localparam int V_WAIT [NV] = '{0, 16, 63, 64, 80, 200, 300};
  localparam int V_CNT [NV]  = '{0, 1, 3, 0, 0, 0, 8};
  localparam int V_PC [NV]   = '{0, 0, 0, 1, 5, 2, 1};

  always #2.5 clk = ~clk;

  interval_tick_timer u_interval_tick_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  function automatic logic [31:0] ctrl(int lim, bit run, bit ie);
    return {6'b0, ie, run, 4'b0, 20'(lim)};
  endfunction

  function automatic logic [31:0] pack(int pc, int c);
    return {12'(pc), 20'(c)};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] v);
    wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check("R12 rvalid after read", 32'(rvalid), 32'd1);
    v = rdata;
  endtask

  initial begin
    #900000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    idle(1);
    do_reset();
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R12 rvalid idle", 32'(rvalid), 0);
    rd(A_CTRL, d); check("R1 ctrl reset", d, 32'h000F_FFFF);
    rd(A_STAT, d); check("R1 status reset", d, 0);
    rd(A_SNAP, d); check("R1 snapshot reset", d, 0);
    idle(1);
    check("R12 rvalid low without read", 32'(rvalid), 0);

    // R2 R3 R7: vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(A_CTRL, ctrl(V_LIM[i], 1, 1));
      idle(V_WAIT[i]);
      check("R7 irq vs flag", 32'(irq), 32'(V_PC[i] > 0));
      rd(A_SNAP, d);
      check("R2/R3 packed count", d, pack(V_PC[i], V_CNT[i]));
    end

    // R4 control readback
    do_reset();
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d); check("R4 ctrl readback masks", d, ctrl(20'hFFFFF, 1, 1));

    // R5 acknowledge clears
    do_reset();
    wr(A_CTRL, ctrl(1, 1, 1));
    idle(64);
    check("R7 irq raised", 32'(irq), 1);
    rd(A_ACK, d); check("R5 ack data", d, pack(2, 0));
    check("R5 irq dropped", 32'(irq), 0);
    rd(A_STAT, d); check("R5 flag cleared", d, 0);
    rd(A_SNAP, d); check("R5 period count cleared", d, pack(0, 0));

    // R6 snapshot has no side effect
    do_reset();
    wr(A_CTRL, ctrl(1, 1, 1));
    idle(64);
    rd(A_SNAP, d); check("R6 first snapshot", d, pack(2, 0));
    rd(A_SNAP, d); check("R6 second snapshot", d, pack(2, 0));
    rd(A_STAT, d); check("R6 flag kept", d, 1);
    check("R6 irq kept", 32'(irq), 1);

    // R7 interrupt enable gating
    do_reset();
    wr(A_CTRL, ctrl(0, 1, 0));
    idle(16);
    check("R7 irq masked", 32'(irq), 0);
    rd(A_STAT, d); check("R7 status flag set", d, 1);
    wr(A_CTRL, ctrl(0, 1, 1));
    check("R7 irq unmasked", 32'(irq), 1);

    // R11 writes to read-only windows ignored
    wr(A_STAT, 0);
    wr(A_ACK, 0);
    wr(A_SNAP, 32'hFFFF_FFFF);
    rd(A_STAT, d); check("R11 flag survives writes", d, 1);
    rd(A_CTRL, d); check("R11 ctrl unchanged", d, ctrl(0, 1, 1));

    // R8 hold and resume
    do_reset();
    wr(A_CTRL, ctrl(7, 1, 1));
    idle(40);
    wr(A_CTRL, ctrl(7, 0, 1));      // 41 enabled edges
    idle(100);
    rd(A_SNAP, d); check("R8 held count", d, pack(0, 2));
    wr(A_CTRL, ctrl(7, 1, 1));
    idle(6);
    rd(A_SNAP, d); check("R8 resume keeps phase", d, pack(0, 2));
    idle(1);
    rd(A_SNAP, d); check("R8 resume next tick", d, pack(0, 3));

    // R9 collision of wrap and acknowledge
    do_reset();
    wr(A_CTRL, ctrl(0, 1, 1));
    idle(31);
    rd(A_ACK, d); check("R9 ack data", d, pack(1, 0));
    check("R9 irq stays", 32'(irq), 1);
    rd(A_SNAP, d); check("R9 period count one", d, pack(1, 0));

    // R10 period count wraps at 12 bits
    do_reset();
    wr(A_CTRL, ctrl(0, 1, 1));
    idle(65552);
    rd(A_SNAP, d); check("R10 period count wrap", d, pack(1, 0));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule